// File: doc/BRIEF.md
# Vector Element Broadcast Unit

This unit receives one already-decoded vector instruction together with its source operand, which has already been fetched, and produces the destination value of a broadcast. It first checks whether the encoding is legal. It then replicates a single 32-bit element, a single 64-bit element, or a whole 128-bit lane across a 128-bit or 256-bit result. Memory access, prefix parsing, operand-address decoding and register storage are all handled outside the block. The source always arrives on a 128-bit input, whether it came from memory or from a register.

The decode fields drive every choice. These are the opcode byte, a length bit, a W bit, a four-bit spare register field, a flag that marks a register source, and two feature enables: a base one and an extended one. Any illegal combination raises an invalid-opcode flag in place of a register write. All results are registered and appear exactly one clock after the input is presented.

Top module: `bcast_unit`

## Requirements
- R1: Opcode 0x18 with the length bit at 0 places four copies of `src_i[31:0]` in `dst_o[127:0]` and drives `dst_o[255:128]` to zero.
- R2: Opcode 0x18 with the length bit at 1 places eight copies of `src_i[31:0]` across all of `dst_o`.
- R3: Opcode 0x19 with the length bit at 1 places four copies of `src_i[63:0]` across `dst_o`.
- R4: Opcode 0x1A with the length bit at 1 copies all of `src_i` into both `dst_o[127:0]` and `dst_o[255:128]`.
- R5: A register source takes only its lowest element: bits 31:0 for opcode 0x18 and bits 63:0 for opcode 0x19. The upper source bits never reach the result.
- R6: Opcodes 0x19 and 0x1A with the length bit at 0 are illegal.
- R7: Any opcode with the W bit at 1 is illegal.
- R8: A spare field value other than 4'b1111 is illegal.
- R9: With a register source, opcode 0x1A is illegal. Opcodes 0x18 and 0x19 are legal only when the extended feature enable is 1, whatever the value of the base enable.
- R10: With a memory source, the base feature enable must be 1. The extended enable alone does not make the form legal.
- R11: Any opcode byte other than 0x18, 0x19 and 0x1A is illegal.
- R12: For an illegal encoding, the output is `ill_op_o`=1, `wr_en_o`=0 and `dst_o` all zero. For a legal encoding, the output is `wr_en_o`=1 and `ill_op_o`=0.
- R13: `out_valid_o` equals `in_valid_i` from one clock earlier. When `out_valid_o` is 0, `ill_op_o`, `wr_en_o` and `dst_o` are all zero. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Descriptor and source are present this cycle |
| opcode_i | input | 8 | Opcode byte |
| len_wide_i | input | 1 | Length bit: 1 selects a 256-bit result |
| w_bit_i | input | 1 | W bit; must be 0 |
| spare_field_i | input | 4 | Spare register field; must be 4'b1111 |
| src_is_reg_i | input | 1 | 1 when the source is a register, 0 when it is memory |
| feat_base_i | input | 1 | Base feature enable |
| feat_ext_i | input | 1 | Extended feature enable |
| src_i | input | 128 | Source operand |
| out_valid_o | output | 1 | Result valid |
| ill_op_o | output | 1 | Invalid-opcode flag |
| wr_en_o | output | 1 | Destination write enable |
| dst_o | output | 256 | Destination value |

## Verification
Every result appears one rising edge after the input is accepted. This applies to legality, the flag, the write enable and the data. The bench drives each descriptor on a falling edge and holds it for one full cycle. It samples the outputs on the next falling edge, after exactly one register stage. Back-to-back descriptors are checked at consecutive falling edges, which shows that no result leaks into the following slot. An idle cycle after a result confirms that the outputs return to zero.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

    localparam int OPC_W   = 8;
    localparam int SPARE_W = 4;

    localparam logic [OPC_W-1:0]   OPC_E32  = 8'h18;
    localparam logic [OPC_W-1:0]   OPC_E64  = 8'h19;
    localparam logic [OPC_W-1:0]   OPC_LANE = 8'h1A;
    localparam logic [SPARE_W-1:0] SPARE_OK = 4'hF;

    typedef enum logic [1:0] {
        KIND_32   = 2'd0,
        KIND_64   = 2'd1,
        KIND_LANE = 2'd2
    } bcast_kind_e;

    typedef struct packed {
        logic        legal;
        bcast_kind_e kind;
        logic        wide;
    } bcast_dec_t;

endpackage

// File: rtl/bcast_decode.sv
module bcast_decode
    import bcast_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic               len_wide_i,
    input  logic               w_bit_i,
    input  logic [SPARE_W-1:0] spare_field_i,
    input  logic               src_is_reg_i,
    input  logic               feat_base_i,
    input  logic               feat_ext_i,
    output bcast_dec_t         dec_o
);

    logic        known;
    logic        len_ok;
    logic        src_ok;
    bcast_kind_e kind;

    // Opcode byte picks the replicated element size.
    always_comb begin
        known = 1'b1;
        kind  = KIND_32;
        unique case (opcode_i)
            OPC_E32:  kind = KIND_32;
            OPC_E64:  kind = KIND_64;
            OPC_LANE: kind = KIND_LANE;
            default:  known = 1'b0;
        endcase
    end

    // Only the 32-bit form has a narrow variant.
    assign len_ok = (kind == KIND_32) || len_wide_i;

    // Register sources need the extended feature and cannot take a lane;
    // memory sources need the base feature.
    always_comb begin
        if (src_is_reg_i) begin
            src_ok = feat_ext_i && (kind != KIND_LANE);
        end else begin
            src_ok = feat_base_i;
        end
    end

    always_comb begin
        dec_o.legal = known && !w_bit_i && (spare_field_i == SPARE_OK)
                      && len_ok && src_ok;
        dec_o.kind  = kind;
        dec_o.wide  = len_wide_i;
    end

endmodule

// File: rtl/bcast_replicate.sv
module bcast_replicate
    import bcast_pkg::*;
#(
    parameter int ELEM_W      = 32,
    parameter int WIDE_ELEM_W = 64,
    parameter int SRC_W       = 128,
    parameter int DST_W       = 256
) (
    input  bcast_kind_e      kind_i,
    input  logic             wide_i,
    input  logic [SRC_W-1:0] src_i,
    output logic [DST_W-1:0] fill_o
);

    localparam int SLOTS     = DST_W / ELEM_W;
    localparam int SRC_SLOTS = SRC_W / ELEM_W;
    localparam int PAIR      = WIDE_ELEM_W / ELEM_W;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam int PAIR_IDX = i % PAIR;
        localparam int LANE_IDX = i % SRC_SLOTS;
        localparam bit IN_LOW   = (i < SRC_SLOTS);

        logic [ELEM_W-1:0] slot;

        always_comb begin
            unique case (kind_i)
                KIND_32: begin
                    if (IN_LOW || wide_i) begin
                        slot = src_i[ELEM_W-1:0];
                    end else begin
                        slot = '0;
                    end
                end
                KIND_64:  slot = src_i[PAIR_IDX*ELEM_W +: ELEM_W];
                default:  slot = src_i[LANE_IDX*ELEM_W +: ELEM_W];
            endcase
        end

        assign fill_o[i*ELEM_W +: ELEM_W] = slot;
    end

endmodule

// File: rtl/bcast_unit.sv
module bcast_unit
    import bcast_pkg::*;
#(
    parameter int SRC_W = 128,
    parameter int DST_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic               len_wide_i,
    input  logic               w_bit_i,
    input  logic [SPARE_W-1:0] spare_field_i,
    input  logic               src_is_reg_i,
    input  logic               feat_base_i,
    input  logic               feat_ext_i,
    input  logic [SRC_W-1:0]   src_i,
    output logic               out_valid_o,
    output logic               ill_op_o,
    output logic               wr_en_o,
    output logic [DST_W-1:0]   dst_o
);

    typedef struct packed {
        logic             valid;
        logic             ill;
        logic             wr_en;
        logic [DST_W-1:0] data;
    } out_state_t;

    bcast_dec_t       dec;
    logic [DST_W-1:0] fill;
    out_state_t       st_d;
    out_state_t       st_q;

    bcast_decode u_decode (
        .opcode_i      (opcode_i),
        .len_wide_i    (len_wide_i),
        .w_bit_i       (w_bit_i),
        .spare_field_i (spare_field_i),
        .src_is_reg_i  (src_is_reg_i),
        .feat_base_i   (feat_base_i),
        .feat_ext_i    (feat_ext_i),
        .dec_o         (dec)
    );

    bcast_replicate #(
        .SRC_W (SRC_W),
        .DST_W (DST_W)
    ) u_replicate (
        .kind_i (dec.kind),
        .wide_i (dec.wide),
        .src_i  (src_i),
        .fill_o (fill)
    );

    always_comb begin
        st_d       = '0;
        st_d.valid = in_valid_i;
        if (in_valid_i) begin
            if (dec.legal) begin
                st_d.wr_en = 1'b1;
                st_d.data  = fill;
            end else begin
                st_d.ill   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign ill_op_o    = st_q.ill;
    assign wr_en_o     = st_q.wr_en;
    assign dst_o       = st_q.data;

endmodule

// File: rtl/bcast_unit_chk.sv
module bcast_unit_chk
    import bcast_pkg::*;
#(
    parameter int SRC_W = 128,
    parameter int DST_W = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid_i,
    input logic [OPC_W-1:0]   opcode_i,
    input logic               len_wide_i,
    input logic               w_bit_i,
    input logic [SPARE_W-1:0] spare_field_i,
    input logic               src_is_reg_i,
    input logic               feat_base_i,
    input logic               feat_ext_i,
    input logic [SRC_W-1:0]   src_i,
    input logic               out_valid_o,
    input logic               ill_op_o,
    input logic               wr_en_o,
    input logic [DST_W-1:0]   dst_o
);

    localparam int HALF = DST_W / 2;

    assert_valid_follow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> out_valid_o);

    assert_valid_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> !out_valid_o);

    assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (!ill_op_o && !wr_en_o && (dst_o == '0)));

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (ill_op_o != wr_en_o));

    assert_ill_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ill_op_o |-> (dst_o == '0));

    assert_wbit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && w_bit_i) |=> ill_op_o);

    assert_spare_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (spare_field_i != SPARE_OK)) |=> ill_op_o);

    assert_short_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !len_wide_i && (opcode_i != OPC_E32)) |=> ill_op_o);

    assert_reg_lane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && src_is_reg_i && ((opcode_i == OPC_LANE) || !feat_ext_i))
        |=> ill_op_o);

    assert_mem_base_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !src_is_reg_i && !feat_base_i) |=> ill_op_o);

    assert_narrow_upper_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && (opcode_i == OPC_E32) && !len_wide_i)
        |=> (dst_o[DST_W-1:HALF] == '0));

    assert_lane_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && ($past(opcode_i) == OPC_LANE))
        |-> (dst_o == {2{$past(src_i)}}));

endmodule

bind bcast_unit bcast_unit_chk #(.SRC_W(SRC_W), .DST_W(DST_W)) u_chk (.*);

// File: tb/tb_bcast_unit.sv
module tb_bcast_unit;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid_i = 1'b0;
    logic [7:0]   opcode_i = 8'h00;
    logic         len_wide_i = 1'b0;
    logic         w_bit_i = 1'b0;
    logic [3:0]   spare_field_i = 4'hF;
    logic         src_is_reg_i = 1'b0;
    logic         feat_base_i = 1'b0;
    logic         feat_ext_i = 1'b0;
    logic [127:0] src_i = '0;
    logic         out_valid_o;
    logic         ill_op_o;
    logic         wr_en_o;
    logic [255:0] dst_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [127:0] SRC_A = 128'hA3A2A1A0_B3B2B1B0_C3C2C1C0_D3D2D1D0;
    localparam logic [127:0] SRC_B = 128'h11112222_33334444_55556666_77778888;

    always #5 clk = ~clk;

    bcast_unit dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid_i    (in_valid_i),
        .opcode_i      (opcode_i),
        .len_wide_i    (len_wide_i),
        .w_bit_i       (w_bit_i),
        .spare_field_i (spare_field_i),
        .src_is_reg_i  (src_is_reg_i),
        .feat_base_i   (feat_base_i),
        .feat_ext_i    (feat_ext_i),
        .src_i         (src_i),
        .out_valid_o   (out_valid_o),
        .ill_op_o      (ill_op_o),
        .wr_en_o       (wr_en_o),
        .dst_o         (dst_o)
    );

    // Expected fill, written from the requirement text.
    function automatic logic [255:0] model_fill(input logic [7:0] op, input logic len,
                                                input logic [127:0] src);
        case (op)
            8'h18:   return len ? {8{src[31:0]}} : {128'b0, {4{src[31:0]}}};
            8'h19:   return {4{src[63:0]}};
            default: return {2{src}};
        endcase
    endfunction

    task automatic drive(input logic [7:0] op, input logic len, input logic w,
                         input logic [3:0] spare, input logic isreg,
                         input logic fb, input logic fe, input logic [127:0] src);
        in_valid_i    = 1'b1;
        opcode_i      = op;
        len_wide_i    = len;
        w_bit_i       = w;
        spare_field_i = spare;
        src_is_reg_i  = isreg;
        feat_base_i   = fb;
        feat_ext_i    = fe;
        src_i         = src;
    endtask

    // Drive on a falling edge, result due at the next falling edge.
    task automatic send(input logic [7:0] op, input logic len, input logic w,
                        input logic [3:0] spare, input logic isreg,
                        input logic fb, input logic fe, input logic [127:0] src);
        drive(op, len, w, spare, isreg, fb, fe, src);
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic expect_ok(input string tag, input logic [255:0] exp);
        checks++;
        if (!(out_valid_o && wr_en_o && !ill_op_o && dst_o == exp)) begin
            failures++;
            $display("FAIL %s: valid=%0b we=%0b ill=%0b dst=%h expected valid=1 we=1 ill=0 dst=%h",
                     tag, out_valid_o, wr_en_o, ill_op_o, dst_o, exp);
        end
    endtask

    task automatic expect_bad(input string tag);
        checks++;
        if (!(out_valid_o && ill_op_o && !wr_en_o && dst_o == '0)) begin
            failures++;
            $display("FAIL %s: valid=%0b we=%0b ill=%0b dst=%h expected valid=1 we=0 ill=1 dst=0",
                     tag, out_valid_o, wr_en_o, ill_op_o, dst_o);
        end
    endtask

    task automatic expect_idle(input string tag);
        checks++;
        if (out_valid_o || ill_op_o || wr_en_o || dst_o != '0) begin
            failures++;
            $display("FAIL %s: valid=%0b we=%0b ill=%0b dst=%h expected all zero",
                     tag, out_valid_o, wr_en_o, ill_op_o, dst_o);
        end
    endtask

    task automatic t_reset();
        in_valid_i = 1'b1;
        repeat (3) @(negedge clk);
        expect_idle("R13 outputs held clear in reset");
        in_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        expect_idle("R13 idle after reset release");
    endtask

    task automatic t_narrow32();
        send(8'h18, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_A);
        expect_ok("R1 32-bit narrow fill", model_fill(8'h18, 1'b0, SRC_A));
    endtask

    task automatic t_wide32();
        send(8'h18, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_B);
        expect_ok("R2 32-bit wide fill", model_fill(8'h18, 1'b1, SRC_B));
    endtask

    task automatic t_dup64();
        send(8'h19, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_A);
        expect_ok("R3 64-bit fill", model_fill(8'h19, 1'b1, SRC_A));
    endtask

    task automatic t_lane128();
        send(8'h1A, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_B);
        expect_ok("R4 128-bit lane copy", model_fill(8'h1A, 1'b1, SRC_B));
    endtask

    task automatic t_regsrc();
        send(8'h18, 1'b1, 1'b0, 4'hF, 1'b1, 1'b0, 1'b1, SRC_A);
        expect_ok("R5 register low 32-bit", {8{SRC_A[31:0]}});
        send(8'h19, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b1, SRC_B);
        expect_ok("R5 register low 64-bit", {4{SRC_B[63:0]}});
        send(8'h18, 1'b0, 1'b0, 4'hF, 1'b1, 1'b0, 1'b1, SRC_B);
        expect_ok("R5 register narrow 32-bit", {128'b0, {4{SRC_B[31:0]}}});
    endtask

    task automatic t_len0();
        send(8'h19, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R6 64-bit form short length");
        send(8'h1A, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R6 lane form short length");
    endtask

    task automatic t_wbit();
        send(8'h18, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R7 W set on 0x18");
        send(8'h1A, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R7 W set on 0x1A");
    endtask

    task automatic t_spare();
        send(8'h18, 1'b1, 1'b0, 4'hE, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R8 spare field 0xE");
        send(8'h19, 1'b1, 1'b0, 4'h7, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R8 spare field 0x7");
    endtask

    task automatic t_regrules();
        send(8'h1A, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b1, SRC_A);
        expect_bad("R9 register lane form");
        send(8'h18, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, SRC_A);
        expect_bad("R9 register 0x18 without extended enable");
        send(8'h19, 1'b1, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, SRC_A);
        expect_bad("R9 register 0x19 without extended enable");
    endtask

    task automatic t_memrules();
        send(8'h18, 1'b1, 1'b0, 4'hF, 1'b0, 1'b0, 1'b1, SRC_A);
        expect_bad("R10 memory with extended enable only");
        send(8'h1A, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_A);
        expect_ok("R10 memory lane with base enable only", model_fill(8'h1A, 1'b1, SRC_A));
    endtask

    task automatic t_badop();
        send(8'h17, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R11 opcode 0x17");
        send(8'h1B, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R11 opcode 0x1B");
        send(8'h58, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b1, SRC_A);
        expect_bad("R11 opcode 0x58");
    endtask

    task automatic t_b2b();
        drive(8'h1A, 1'b1, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_A);
        @(negedge clk);
        expect_ok("R13 first of back-to-back", model_fill(8'h1A, 1'b1, SRC_A));
        drive(8'h18, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0, SRC_A);
        @(negedge clk);
        expect_bad("R12 illegal after legal clears data");
        drive(8'h18, 1'b0, 1'b0, 4'hF, 1'b0, 1'b1, 1'b0, SRC_B);
        @(negedge clk);
        in_valid_i = 1'b0;
        expect_ok("R13 third of back-to-back", model_fill(8'h18, 1'b0, SRC_B));
        @(negedge clk);
        expect_idle("R13 idle cycle after results");
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        t_reset();
        t_narrow32();
        t_wide32();
        t_dup64();
        t_lane128();
        t_regsrc();
        t_len0();
        t_wbit();
        t_spare();
        t_regrules();
        t_memrules();
        t_badop();
        t_b2b();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            report();
        end
    end

endmodule